// File: doc/BRIEF.md
# Inter-VM Doorbell Register Bank

This block is the small register window of a shared-memory device that links virtual machines. Software sees four 32-bit words. The first is an interrupt mask, which is simply stored. The second is an interrupt status word, which empties when it is read. The third is a read-only word that reports the local machine's own peer number. The fourth is a write-only doorbell.

A write to the doorbell names a destination peer and a vector in one word. If both are valid, the block sends a single-cycle notify strobe to the fabric that delivers events between machines. The destination is valid when it is below the current peer limit. The vector is valid when it is below the number of vectors that the destination peer has registered. A side configuration port loads those per-peer vector counts into a small table.

An incoming local event marks the status word when the device runs without message-signalled interrupts. In the other mode the event is left to the interrupt logic outside this block.

Top module: `peer_doorbell_regs`

## Requirements
- R1: After reset, the mask and status words read as zero, every per-peer vector count is zero, and the notify strobe is low.
- R2: A write to byte offset 0 stores all 32 bits of write data into the mask word. A read at offset 0 returns that word.
- R3: A write to byte offset 4 stores all 32 bits into the status word. A read at offset 4 returns the stored value and clears the word to zero in the same access, so the next read returns zero.
- R4: A read at byte offset 8 returns the own-ID input, zero-extended to 32 bits. Writes to offset 8 have no effect.
- R5: Writes decode only address bits 7:2, so a write to offset 1 lands in the mask word. Reads decode the full byte offset, so a read at offset 1 returns zero.
- R6: A doorbell write is a write to offset 12. Bits 31:16 carry the destination peer and bits 7:0 carry the vector; bits 15:8 are ignored. An accepted doorbell write raises the notify strobe for exactly one cycle, the cycle after the write, with the peer and the vector on the notify outputs.
- R7: A doorbell write is dropped, with no strobe, when the destination is greater than or equal to the peer-limit input, or greater than or equal to the table size.
- R8: A doorbell write is dropped when the vector is greater than or equal to the destination's registered count. The configuration port writes a count into the table entry it selects.
- R9: A read at offset 12, or at any unmapped offset, returns zero. A write to an unmapped offset changes neither the mask nor the status word.
- R10: While the interrupt-mode input is 0, a local event loads the value 1 into the status word, taking priority over a status write in the same cycle. While the mode input is 1, a local event has no effect.
- R11: When a status read and a legacy-mode event fall in the same cycle, the read returns the old value and the status word ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| own_id | input | 16 | Local peer number |
| msi_mode | input | 1 | 1 selects message-signalled mode, in which events are ignored |
| local_evt | input | 1 | Incoming event for this machine |
| peer_limit | input | 5 | Number of peers currently valid |
| cfg_we | input | 1 | Vector-count table write strobe |
| cfg_peer | input | 4 | Table entry to write |
| cfg_count | input | 8 | Vector count to store |
| ntf_valid | output | 1 | One-cycle notify strobe |
| ntf_peer | output | 16 | Destination peer of the notify |
| ntf_vec | output | 8 | Vector of the notify |

## Verification
Every result leaves through one register stage. Read data for a request sampled at edge N is due after edge N. A doorbell strobe also appears after the edge that samples the write, and it must be gone one edge later. The side effects of a status read, or of an event, can be observed with the next read. The bench drives inputs on falling edges and samples at the falling edge after the edge that samples them. Each write task checks the notify outputs in the cycle after the write and again one cycle later. This covers both acceptance and the one-cycle width of the strobe. Each read task compares the returned word exactly.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned ID_W   = 16;
  localparam int unsigned VEC_W  = 8;

  // word slots decoded from address bits 7:2 on writes
  localparam logic [5:0] SLOT_MASK = 6'd0;
  localparam logic [5:0] SLOT_STAT = 6'd1;
  localparam logic [5:0] SLOT_POS  = 6'd2;
  localparam logic [5:0] SLOT_RING = 6'd3;

  function automatic logic [ID_W-1:0] ring_dest(input logic [REG_W-1:0] w);
    return w[31:16];
  endfunction

  function automatic logic [VEC_W-1:0] ring_vec(input logic [REG_W-1:0] w);
    return w[7:0];
  endfunction

  function automatic logic ring_ok(input logic [ID_W-1:0]  dest,
                                   input logic [VEC_W-1:0] vec,
                                   input logic [ID_W-1:0]  limit,
                                   input logic [VEC_W-1:0] cnt);
    return (dest < limit) && (vec < cnt);
  endfunction
endpackage

// File: rtl/dbell_regfile.sv
module dbell_regfile
  import dbell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [ID_W-1:0]   own_id,
  input  logic              msi_mode,
  input  logic              evt,
  output logic [REG_W-1:0]  rdata,
  output logic              ring_wr
);
  logic [REG_W-1:0] mask_q, stat_q, rd_val;
  logic [5:0] wr_slot;
  logic wr_mask_hit, wr_stat_hit, rd_stat_hit, evt_set;

  assign wr_slot     = addr[7:2];
  assign wr_mask_hit = wr && (wr_slot == SLOT_MASK);
  assign wr_stat_hit = wr && (wr_slot == SLOT_STAT);
  assign ring_wr     = wr && (wr_slot == SLOT_RING);
  assign rd_stat_hit = rd && (addr == ADDR_W'(4));
  assign evt_set     = evt && !msi_mode;

  always_comb begin
    rd_val = '0;
    if (rd) begin
      case (addr)
        ADDR_W'(0): rd_val = mask_q;
        ADDR_W'(4): rd_val = stat_q;
        ADDR_W'(8): rd_val = REG_W'(own_id);
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
      rdata  <= '0;
    end else begin
      rdata <= rd_val;
      if (wr_mask_hit) mask_q <= wdata;
      if (evt_set)          stat_q <= REG_W'(1);
      else if (wr_stat_hit) stat_q <= wdata;
      else if (rd_stat_hit) stat_q <= '0;
    end
  end

  // R2
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_hit |=> mask_q == $past(wdata));
  // R3
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_hit && !evt_set && !wr_stat_hit) |=> stat_q == '0);
  // R10
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set |=> stat_q == REG_W'(1));
  // R10
  msi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_mode && evt && !wr_stat_hit && !rd_stat_hit) |=> $stable(stat_q));
endmodule

// File: rtl/dbell_vec_table.sv
module dbell_vec_table
  import dbell_pkg::*;
#(
  parameter int unsigned PEERS = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [VEC_W-1:0] cfg_cnt,
  input  logic [IDX_W-1:0] look_idx,
  output logic [VEC_W-1:0] look_cnt
);
  logic [VEC_W-1:0] cnt_q [PEERS];

  for (genvar g = 0; g < PEERS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                 cnt_q[g] <= '0;
      else if (cfg_we && cfg_idx == IDX_W'(g))    cnt_q[g] <= cfg_cnt;
    end
  end

  always_comb begin
    look_cnt = '0;
    for (int i = 0; i < PEERS; i++)
      if (look_idx == IDX_W'(i)) look_cnt = cnt_q[i];
  end
endmodule

// File: rtl/dbell_ring.sv
module dbell_ring
  import dbell_pkg::*;
#(
  parameter int unsigned PEERS = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned LIM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [LIM_W-1:0] peer_limit,
  output logic [IDX_W-1:0] look_idx,
  input  logic [VEC_W-1:0] look_cnt,
  output logic             ntf_valid,
  output logic [ID_W-1:0]  ntf_peer,
  output logic [VEC_W-1:0] ntf_vec
);
  logic [ID_W-1:0]  dest;
  logic [VEC_W-1:0] vec;
  logic in_tab, ring_go;

  assign dest     = ring_dest(wdata);
  assign vec      = ring_vec(wdata);
  assign look_idx = dest[IDX_W-1:0];
  assign in_tab   = dest < ID_W'(PEERS);
  assign ring_go  = ring_wr && in_tab &&
                    ring_ok(dest, vec, ID_W'(peer_limit), look_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ntf_valid <= 1'b0;
      ntf_peer  <= '0;
      ntf_vec   <= '0;
    end else begin
      ntf_valid <= ring_go;
      if (ring_go) begin
        ntf_peer <= dest;
        ntf_vec  <= vec;
      end
    end
  end

  // R6
  ring_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> $past(ring_wr));
  // R7
  ring_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (ntf_peer < ID_W'($past(peer_limit))) && (ntf_peer < ID_W'(PEERS)));
  // R8
  ring_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> ntf_vec < $past(look_cnt));
endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
  import dbell_pkg::*;
#(
  parameter int unsigned PEERS = 16,
  localparam int unsigned IDX_W = (PEERS > 1) ? $clog2(PEERS) : 1,
  localparam int unsigned LIM_W = $clog2(PEERS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [ID_W-1:0]   own_id,
  input  logic              msi_mode,
  input  logic              local_evt,
  input  logic [LIM_W-1:0]  peer_limit,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_peer,
  input  logic [VEC_W-1:0]  cfg_count,
  output logic              ntf_valid,
  output logic [ID_W-1:0]   ntf_peer,
  output logic [VEC_W-1:0]  ntf_vec
);
  logic             ring_wr;
  logic [IDX_W-1:0] look_idx;
  logic [VEC_W-1:0] look_cnt;

  dbell_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .own_id(own_id), .msi_mode(msi_mode), .evt(local_evt),
    .rdata(bus_rdata), .ring_wr(ring_wr)
  );

  dbell_vec_table #(.PEERS(PEERS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_peer),
    .cfg_cnt(cfg_count), .look_idx(look_idx), .look_cnt(look_cnt)
  );

  dbell_ring #(.PEERS(PEERS), .IDX_W(IDX_W), .LIM_W(LIM_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .ring_wr(ring_wr), .wdata(bus_wdata),
    .peer_limit(peer_limit), .look_idx(look_idx), .look_cnt(look_cnt),
    .ntf_valid(ntf_valid), .ntf_peer(ntf_peer), .ntf_vec(ntf_vec)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !ntf_valid && bus_rdata == '0);
endmodule

// File: tb/peer_doorbell_regs_bench.sv
`timescale 1ns/1ps
module peer_doorbell_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] own_id = 16'h0002;
  logic        msi_mode = 1'b0, local_evt = 1'b0;
  logic [4:0]  peer_limit = 5'd4;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_peer = '0;
  logic [7:0]  cfg_count = '0;
  logic        ntf_valid;
  logic [15:0] ntf_peer;
  logic [7:0]  ntf_vec;

  int runs = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  peer_doorbell_regs u_peer_doorbell_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .own_id(own_id), .msi_mode(msi_mode), .local_evt(local_evt),
    .peer_limit(peer_limit), .cfg_we(cfg_we), .cfg_peer(cfg_peer),
    .cfg_count(cfg_count), .ntf_valid(ntf_valid), .ntf_peer(ntf_peer),
    .ntf_vec(ntf_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_load(input logic [3:0] p, input logic [7:0] c);
    @(negedge clk); cfg_we = 1'b1; cfg_peer = p; cfg_count = c;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // write, then check the notify outputs for the next two cycles
  task automatic wr_chk(input string req, input logic [7:0] a, input logic [31:0] d,
                        input bit exp_v, input logic [15:0] exp_p, input logic [7:0] exp_vec);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    chk(req, {31'd0, ntf_valid}, {31'd0, exp_v});
    if (exp_v) begin
      chk(req, {16'd0, ntf_peer}, {16'd0, exp_p});
      chk(req, {24'd0, ntf_vec}, {24'd0, exp_vec});
    end
    @(negedge clk);
    chk(req, {31'd0, ntf_valid}, 32'd0);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp,
                        input bit with_evt);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; local_evt = with_evt;
    @(negedge clk); bus_rd = 1'b0; local_evt = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse_evt();
    @(negedge clk); local_evt = 1'b1;
    @(negedge clk); local_evt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 notify", {31'd0, ntf_valid}, 32'd0);
    rd_chk("R1 mask", 8'h00, 32'd0, 1'b0);
    rd_chk("R1 status", 8'h04, 32'd0, 1'b0);
    wr_chk("R1 empty table", 8'h0C, {16'd0, 8'd0, 8'd0}, 1'b0, 16'd0, 8'd0);
  endtask

  task automatic t_mask();
    wr_chk("R2 write", 8'h00, 32'hA5A5_5A5A, 1'b0, 16'd0, 8'd0);
    rd_chk("R2 read", 8'h00, 32'hA5A5_5A5A, 1'b0);
    wr_chk("R5 low bits", 8'h01, 32'h1234_5678, 1'b0, 16'd0, 8'd0);
    rd_chk("R5 write alias", 8'h00, 32'h1234_5678, 1'b0);
    rd_chk("R5 read exact", 8'h01, 32'd0, 1'b0);
  endtask

  task automatic t_status();
    wr_chk("R3 write", 8'h04, 32'hDEAD_BEEF, 1'b0, 16'd0, 8'd0);
    rd_chk("R3 read", 8'h04, 32'hDEAD_BEEF, 1'b0);
    rd_chk("R3 cleared", 8'h04, 32'd0, 1'b0);
  endtask

  task automatic t_position();
    rd_chk("R4 id", 8'h08, 32'h0000_0002, 1'b0);
    wr_chk("R4 write ignored", 8'h08, 32'hFFFF_FFFF, 1'b0, 16'd0, 8'd0);
    rd_chk("R4 id kept", 8'h08, 32'h0000_0002, 1'b0);
  endtask

  task automatic t_ring();
    wr_chk("R6 accept", 8'h0C, {16'd3, 8'hFF, 8'd3}, 1'b1, 16'd3, 8'd3);
    wr_chk("R6 peer1", 8'h0C, {16'd1, 8'h00, 8'd0}, 1'b1, 16'd1, 8'd0);
    rd_chk("R9 ring read", 8'h0C, 32'd0, 1'b0);
    wr_chk("R7 at limit", 8'h0C, {16'd4, 8'd0, 8'd0}, 1'b0, 16'd0, 8'd0);
    wr_chk("R7 past limit", 8'h0C, {16'd15, 8'd0, 8'd0}, 1'b0, 16'd0, 8'd0);
    @(negedge clk); peer_limit = 5'd16;
    wr_chk("R7 raised limit", 8'h0C, {16'd15, 8'd0, 8'd7}, 1'b1, 16'd15, 8'd7);
    wr_chk("R7 beyond table", 8'h0C, {16'd16, 8'd0, 8'd0}, 1'b0, 16'd0, 8'd0);
    wr_chk("R8 zero count", 8'h0C, {16'd2, 8'd0, 8'd0}, 1'b0, 16'd0, 8'd0);
    wr_chk("R8 vec at count", 8'h0C, {16'd0, 8'd0, 8'd2}, 1'b0, 16'd0, 8'd0);
    wr_chk("R8 vec below count", 8'h0C, {16'd0, 8'd0, 8'd1}, 1'b1, 16'd0, 8'd1);
    wr_chk("R8 vec at count p15", 8'h0C, {16'd15, 8'd0, 8'd8}, 1'b0, 16'd0, 8'd0);
    @(negedge clk); peer_limit = 5'd4;
  endtask

  task automatic t_unmapped();
    wr_chk("R9 setup mask", 8'h00, 32'h0000_00C3, 1'b0, 16'd0, 8'd0);
    wr_chk("R9 setup status", 8'h04, 32'h0000_0005, 1'b0, 16'd0, 8'd0);
    wr_chk("R9 wr 0x10", 8'h10, 32'hFFFF_FFFF, 1'b0, 16'd0, 8'd0);
    wr_chk("R9 wr 0xFC", 8'hFC, 32'hFFFF_FFFF, 1'b0, 16'd0, 8'd0);
    rd_chk("R9 rd 0x10", 8'h10, 32'd0, 1'b0);
    rd_chk("R9 mask kept", 8'h00, 32'h0000_00C3, 1'b0);
    rd_chk("R9 status kept", 8'h04, 32'h0000_0005, 1'b0);
  endtask

  task automatic t_event();
    msi_mode = 1'b0;
    pulse_evt();
    rd_chk("R10 legacy set", 8'h04, 32'd1, 1'b0);
    rd_chk("R10 then clear", 8'h04, 32'd0, 1'b0);
    @(negedge clk); msi_mode = 1'b1;
    pulse_evt();
    rd_chk("R10 msi ignored", 8'h04, 32'd0, 1'b0);
    @(negedge clk); msi_mode = 1'b0;
    // event beats a status write in the same cycle
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_0099; local_evt = 1'b1;
    @(negedge clk); bus_wr = 1'b0; local_evt = 1'b0;
    rd_chk("R10 event over write", 8'h04, 32'd1, 1'b0);
  endtask

  task automatic t_collide();
    wr_chk("R11 setup", 8'h04, 32'h0000_0077, 1'b0, 16'd0, 8'd0);
    rd_chk("R11 old value", 8'h04, 32'h0000_0077, 1'b1);
    rd_chk("R11 event kept", 8'h04, 32'd1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    cfg_load(4'd0, 8'd2);
    cfg_load(4'd1, 8'd1);
    cfg_load(4'd3, 8'd4);
    cfg_load(4'd15, 8'd8);
    t_mask();
    t_status();
    t_position();
    t_ring();
    t_unmapped();
    t_event();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      runs++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule